// File: doc/BRIEF.md
# Register-File Multiply-Accumulate Instruction Unit

This block is a multi-cycle execution unit that hangs off a processor's custom-operation slot. Each issued operation multiplies two 32-bit operands and adds the product into a private accumulator. The new accumulator value is the operation's result.

Operand A comes either from the processor or from an entry of a private 32 x 32-bit register file. Operand B comes either from the processor or from the accumulator itself. The accumulator feedback lets a chain of operations raise values to powers, or scale the running sum, without a round trip through the processor. The result is always presented to the processor. When the issuing instruction asks for it, the result is also written into a local register, so later operations can pick it up as operand A.

The processor issues an operation with a one-cycle `op_go` strobe. It holds the select flags and indices stable until `op_done`. Every register in the block advances only on cycles where `clk_en` is high.

Top module: `regfile_mac_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the accumulator, `mac_out`, `op_done` and all local registers. Right after reset, `op_done` is 0 and `mac_out` is 0.
- R2: An operation accepted at enabled edge E0 completes at the next enabled edge. `op_done` is then 1 for exactly one enabled cycle.
- R3: With `a_from_cpu`=1, operand A is `cpu_opa`. With `a_from_cpu`=0, operand A is local register `src_a_idx`, and `cpu_opa` has no effect.
- R4: With `b_from_acc`=1, operand B is the accumulator value at acceptance, and `cpu_opb` has no effect. With `b_from_acc`=0, operand B is `cpu_opb`.
- R5: On completion, the new accumulator equals the old accumulator plus A*B, kept to the low 32 bits. This value is shown on `mac_out` while `op_done` is 1, and `mac_out` changes at no other time than completion or reset.
- R6: With `ret_to_cpu`=0, the result is also written to local register `dst_idx`. With `ret_to_cpu`=1, no local register changes.
- R7: While `clk_en` is low, nothing advances: a pending operation waits, `op_done` and `mac_out` hold, and `op_go` is not accepted.
- R8: `op_go` seen while an operation is executing is ignored. Each accepted operation gives exactly one completion.
- R9: A new operation may be accepted in the same cycle that `op_done` of the previous one is high. It reads the accumulator and any local register already updated by that previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clk_en | input | 1 | Clock qualifier; the block advances only when high |
| rst_n | input | 1 | Synchronous active-low reset |
| op_go | input | 1 | Issue strobe for a new operation |
| a_from_cpu | input | 1 | 1: operand A from `cpu_opa`; 0: from local register |
| b_from_acc | input | 1 | 1: operand B is the accumulator; 0: from `cpu_opb` |
| ret_to_cpu | input | 1 | 1: result to processor only; 0: also write local register |
| src_a_idx | input | 5 | Local register index for operand A |
| dst_idx | input | 5 | Local register index for the result write |
| cpu_opa | input | 32 | Processor-supplied operand A |
| cpu_opb | input | 32 | Processor-supplied operand B |
| op_done | output | 1 | Completion pulse |
| mac_out | output | 32 | New accumulator value |

## Verification
The two functions that meet in one cycle are completion and issue: the `op_done` of one operation and the acceptance of the next. That cycle is also where a just-written local register and the just-updated accumulator become the next operation's inputs. The bench provokes this by raising `op_go` with a read of the freshly written register in the very cycle `op_done` is sampled high. It judges the second result against a model that applies the first write before the second read. A second overlap, a clock-enable drop while `op_done` is high, is checked for the done pulse being held rather than lost or repeated.

// File: rtl/mac_pkg.sv
// Shared types for the register-file multiply-accumulate unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mac_pkg;

    // Sequencer states: waiting for an issue, or executing one.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_EXEC = 1'b1
    } seq_state_t;

endpackage

// File: rtl/mac_regfile.sv
// Private register file of the unit: DEPTH words of DATA_W bits.
// One asynchronous read port and one synchronous write port.
// Assumes a synchronous active-low reset that clears every entry.
module mac_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage update: clear on reset, else write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Read port: combinational lookup of the addressed entry.
    always_comb begin
        rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/mac_seq.sv
// Issue sequencer: accepts an operation when idle and enabled, then
// completes it on the following enabled edge.
// Assumes clk_en qualifies every state change.
module mac_seq
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic op_go,
    output logic capture,
    output logic finish
);

    seq_state_t state_q;

    // Handshake decode: accept in idle, finish from exec, both gated by clk_en.
    always_comb begin
        capture = clk_en && (state_q == SEQ_IDLE) && op_go;
        finish  = clk_en && (state_q == SEQ_EXEC);
    end

    // State register: idle -> exec on accept, exec -> idle on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (capture) begin
            state_q <= SEQ_EXEC;
        end else if (finish) begin
            state_q <= SEQ_IDLE;
        end
    end

endmodule

// File: rtl/mac_datapath.sv
// Operand selection, multiply-add and accumulator of the unit.
// Captures the operands and the destination on accept, then forms
// acc + A*B (low DATA_W bits) and commits it on finish.
// Assumes capture and finish are never high together.
module mac_datapath #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              capture,
    input  logic              finish,
    input  logic              a_from_cpu,
    input  logic              b_from_acc,
    input  logic              ret_to_cpu,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] cpu_opa,
    input  logic [DATA_W-1:0] cpu_opb,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              op_done,
    output logic [DATA_W-1:0] mac_out
);

    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] opb_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] out_q;
    logic              ret_q;
    logic [IDX_W-1:0]  dst_q;
    logic              done_q;
    logic [DATA_W-1:0] opa_sel;
    logic [DATA_W-1:0] opb_sel;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] sum;

    // Operand muxes: processor port or local register for A, accumulator or port for B.
    always_comb begin
        opa_sel = a_from_cpu ? cpu_opa : rf_rd_data;
        opb_sel = b_from_acc ? acc_q   : cpu_opb;
    end

    // Arithmetic: low bits of the product added to the accumulator.
    always_comb begin
        prod = opa_q * opb_q;
        sum  = acc_q + prod;
    end

    // Operand, destination and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            acc_q <= '0;
            out_q <= '0;
            ret_q <= 1'b1;
            dst_q <= '0;
        end else if (capture) begin
            opa_q <= opa_sel;
            opb_q <= opb_sel;
            ret_q <= ret_to_cpu;
            dst_q <= dst_idx;
        end else if (finish) begin
            acc_q <= sum;
            out_q <= sum;
        end
    end

    // Completion flag: follows finish on enabled edges, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (clk_en) begin
            done_q <= finish;
        end
    end

    // Local write request and outputs.
    always_comb begin
        rf_wr_en   = finish && !ret_q;
        rf_wr_idx  = dst_q;
        rf_wr_data = sum;
        op_done    = done_q;
        mac_out    = out_q;
    end

endmodule

// File: rtl/regfile_mac_unit.sv
// Top of the register-file multiply-accumulate instruction unit.
// Ties the sequencer, the datapath and the private register file.
// Assumes flags and indices stay stable from issue to op_done.
module regfile_mac_unit #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              rst_n,
    input  logic              op_go,
    input  logic              a_from_cpu,
    input  logic              b_from_acc,
    input  logic              ret_to_cpu,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] cpu_opa,
    input  logic [DATA_W-1:0] cpu_opb,
    output logic              op_done,
    output logic [DATA_W-1:0] mac_out
);

    logic              capture;
    logic              finish;
    logic              rf_wr_en;
    logic [IDX_W-1:0]  rf_wr_idx;
    logic [DATA_W-1:0] rf_wr_data;
    logic [DATA_W-1:0] rf_rd_data;

    mac_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .op_go   (op_go),
        .capture (capture),
        .finish  (finish)
    );

    mac_datapath #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .capture    (capture),
        .finish     (finish),
        .a_from_cpu (a_from_cpu),
        .b_from_acc (b_from_acc),
        .ret_to_cpu (ret_to_cpu),
        .dst_idx    (dst_idx),
        .cpu_opa    (cpu_opa),
        .cpu_opb    (cpu_opb),
        .rf_rd_data (rf_rd_data),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_idx  (rf_wr_idx),
        .rf_wr_data (rf_wr_data),
        .op_done    (op_done),
        .mac_out    (mac_out)
    );

    mac_regfile #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr_en),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .rd_idx  (src_a_idx),
        .rd_data (rf_rd_data)
    );

endmodule

// File: rtl/regfile_mac_unit_chk.sv
// Protocol checker for regfile_mac_unit, attached by bind.
// Observes only top-level ports.
module regfile_mac_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              op_done,
    input logic [DATA_W-1:0] mac_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!op_done && mac_out == '0)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && clk_en) |=> !op_done); // R2

    AST_DONE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $rose(op_done)) |-> $past(clk_en)); // R2

    AST_OUT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$stable(mac_out)) |-> op_done); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(op_done) && $stable(mac_out))); // R7

endmodule

bind regfile_mac_unit regfile_mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .op_done (op_done),
    .mac_out (mac_out)
);

// File: tb/regfile_mac_unit_tb.sv
module regfile_mac_unit_tb;

    logic        clk = 1'b0;
    logic        clk_en = 1'b1;
    logic        rst_n = 1'b0;
    logic        op_go = 1'b0;
    logic        a_from_cpu = 1'b1;
    logic        b_from_acc = 1'b0;
    logic        ret_to_cpu = 1'b1;
    logic [4:0]  src_a_idx = '0;
    logic [4:0]  dst_idx = '0;
    logic [31:0] cpu_opa = '0;
    logic [31:0] cpu_opb = '0;
    logic        op_done;
    logic [31:0] mac_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] acc_m;
    logic [31:0] rf_m [32];

    always #5 clk = ~clk;

    regfile_mac_unit u_dut (
        .clk (clk), .clk_en (clk_en), .rst_n (rst_n), .op_go (op_go),
        .a_from_cpu (a_from_cpu), .b_from_acc (b_from_acc), .ret_to_cpu (ret_to_cpu),
        .src_a_idx (src_a_idx), .dst_idx (dst_idx),
        .cpu_opa (cpu_opa), .cpu_opb (cpu_opb),
        .op_done (op_done), .mac_out (mac_out)
    );

    // {a_from_cpu, b_from_acc, ret_to_cpu, src_a_idx, dst_idx, cpu_opa, cpu_opb, expected}
    localparam int VW = 109;
    localparam logic [VW-1:0] VEC [8] = '{
        {3'b101, 5'd0,  5'd0,  32'd3,          32'd5,          32'h0000000F},
        {3'b100, 5'd0,  5'd4,  32'd2,          32'd10,         32'h00000023},
        {3'b001, 5'd4,  5'd0,  32'd999,        32'd2,          32'h00000069},
        {3'b110, 5'd0,  5'd31, 32'd2,          32'd7777,       32'h0000013B},
        {3'b011, 5'd31, 5'd0,  32'd0,          32'd0,          32'h000184D4},
        {3'b100, 5'd0,  5'd0,  32'hFFFFFFFF,   32'hFFFFFFFF,   32'h000184D5},
        {3'b001, 5'd0,  5'd0,  32'd0,          32'h00010000,   32'h84D684D5},
        {3'b001, 5'd7,  5'd0,  32'd5,          32'h00012345,   32'h84D684D5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit fa, input bit fb, input bit wr, input logic [4:0] ia,
                         input logic [4:0] ic, input logic [31:0] a, input logic [31:0] b);
        a_from_cpu = fa; b_from_acc = fb; ret_to_cpu = wr;
        src_a_idx = ia; dst_idx = ic; cpu_opa = a; cpu_opb = b;
        op_go = 1'b1;
    endtask

    // Bench model of one operation; updates acc_m and rf_m, returns the result.
    function automatic logic [31:0] model(input bit fa, input bit fb, input bit wr,
                                          input logic [4:0] ia, input logic [4:0] ic,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] av, bv, s;
        av = fa ? a : rf_m[ia];
        bv = fb ? acc_m : b;
        s = acc_m + av * bv;
        acc_m = s;
        if (!wr) rf_m[ic] = s;
        return s;
    endfunction

    // Issue from a negedge; return at the negedge after completion.
    task automatic run_op(input bit fa, input bit fb, input bit wr, input logic [4:0] ia,
                          input logic [4:0] ic, input logic [31:0] a, input logic [31:0] b,
                          input string req);
        logic [31:0] e;
        e = model(fa, fb, wr, ia, ic, a, b);
        drive(fa, fb, wr, ia, ic, a, b);
        @(posedge clk); @(negedge clk);
        op_go = 1'b0;
        chk({req, " busy no done"}, {31'd0, op_done}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk({req, " done"}, {31'd0, op_done}, 32'd1);
        chk({req, " result"}, mac_out, e);
    endtask

    task automatic reset_model();
        acc_m = '0;
        for (int i = 0; i < 32; i++) rf_m[i] = '0;
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [31:0] held;
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done after reset", {31'd0, op_done}, 32'd0);
        chk("R1 out after reset", mac_out, 32'd0);

        // Table walk: R3 R4 R5 R6, including ignored ports and wrap.
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            drive(v[108], v[107], v[106], v[105:101], v[100:96], v[95:64], v[63:32]);
            @(posedge clk); @(negedge clk);
            op_go = 1'b0;
            @(posedge clk); @(negedge clk);
            chk($sformatf("R5 R3 R4 vector %0d done", i), {31'd0, op_done}, 32'd1);
            chk($sformatf("R5 R3 R4 vector %0d result", i), mac_out, v[31:0]);
            acc_m = v[31:0];
            if (!v[106]) rf_m[v[100:96]] = v[31:0];
            @(posedge clk); @(negedge clk);
            chk($sformatf("R2 vector %0d single pulse", i), {31'd0, op_done}, 32'd0);
        end

        // R6: returning to processor leaves local register 9 untouched.
        run_op(1, 0, 1, 5'd0, 5'd9, 32'd1, 32'd1, "R6 return only");
        @(negedge clk);
        run_op(0, 0, 1, 5'd9, 5'd0, 32'hDEAD, 32'd1, "R6 reg9 still zero");
        @(negedge clk);

        // R9: issue in the cycle op_done is high; read the register just written.
        run_op(1, 0, 0, 5'd0, 5'd12, 32'd3, 32'd4, "R9 first op");
        held = model(0, 1, 1, 5'd12, 5'd0, 32'd0, 32'd0);
        drive(0, 1, 1, 5'd12, 5'd0, 32'd0, 32'd0);
        @(posedge clk); @(negedge clk);
        op_go = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 back-to-back done", {31'd0, op_done}, 32'd1);
        chk("R9 back-to-back result", mac_out, held);
        @(negedge clk);

        // R7: clk_en low stalls a pending op and ignores op_go.
        held = model(1, 1, 1, 5'd0, 5'd0, 32'd2, 32'd0);
        drive(1, 1, 1, 5'd0, 5'd0, 32'd2, 32'd0);
        @(posedge clk); @(negedge clk);
        clk_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R7 stalled no done", {31'd0, op_done}, 32'd0);
        end
        op_go = 1'b0;
        clk_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 done after stall", {31'd0, op_done}, 32'd1);
        chk("R7 result after stall", mac_out, held);
        clk_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 done held", {31'd0, op_done}, 32'd1);
        chk("R7 out held", mac_out, held);
        clk_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 done clears once enabled", {31'd0, op_done}, 32'd0);

        // R7: op_go while disabled and idle is not accepted.
        clk_en = 1'b0;
        drive(1, 0, 1, 5'd0, 5'd0, 32'd7, 32'd7);
        repeat (2) @(posedge clk);
        @(negedge clk);
        op_go = 1'b0;
        clk_en = 1'b1;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk("R7 disabled go ignored", {31'd0, op_done}, 32'd0);
        end

        // R8: op_go held through execution yields one completion.
        held = model(1, 0, 1, 5'd0, 5'd0, 32'd5, 32'd6);
        drive(1, 0, 1, 5'd0, 5'd0, 32'd5, 32'd6);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        op_go = 1'b0;
        chk("R8 one done", {31'd0, op_done}, 32'd1);
        chk("R8 result", mac_out, held);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk("R8 no second done", {31'd0, op_done}, 32'd0);
        end
        run_op(1, 0, 1, 5'd0, 5'd0, 32'd0, 32'd0, "R8 acc advanced once");
        @(negedge clk);

        // R1: mid-run reset clears accumulator and local registers.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        reset_model();
        chk("R1 done after second reset", {31'd0, op_done}, 32'd0);
        chk("R1 out after second reset", mac_out, 32'd0);
        run_op(0, 0, 1, 5'd4, 5'd0, 32'd9, 32'd1, "R1 reg4 and acc cleared");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule